// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block drives the clock and data lines of an I2C master at the level of single bus conditions. It takes one command at a time: start, write one bit, read one bit, or stop. It then produces the matching SCL and SDA waveform, timed entirely in cycles of a fast input clock. Both lines are reported as levels, where 1 means released and 0 means pulled low. The surrounding byte engine applies them to open-drain pads.

The SCL low and high phases are counted in units of eight input clocks. Their lengths come from two dividers packed into one 32-bit word. Three small tuning fields set further timings:
- the point within the low phase at which SDA changes;
- how long SCL stays high before SDA falls for a start;
- how long SCL stays high before SDA rises for a stop.

A start issued while the bus is held low by a previous bit becomes a repeated start. The bus is first raised through a normal low phase. All timing settings are captured when a command is accepted. The block pulses `done` for one clock when the bus phase of that command ends, and keeps the last sampled SDA value of a read on `rd_bit`.

Top module: `i2c_bit_timer`

## Requirements
In the requirements below, l = cfg_div[15:0]+1 and h = cfg_div[31:16]+1. s = cfg_sda_upd+1, ranging 1..8. u = cfg_start_su+1 and p = cfg_stop_su+1, each ranging 1..4. Cycle index 0 is the first cycle after the rising clock edge that accepts a command. A command is accepted on a rising edge where `cmd_valid` and `cmd_ready` are both 1. Command codes on `cmd_op` are: 0 start, 1 write bit, 2 read bit, 3 stop.

- R1: After reset, and whenever the bus is idle, `scl_o` and `sda_o` are both 1, `done` is 0 and `cmd_ready` is 1.
- R2: A write or read bit holds `scl_o` low from index 0 to index 8l-1. It drives `scl_o` high from index 8l to 8l+8h-1. At index 8l+8h, `scl_o` falls and `done` is 1 for exactly that one cycle.
- R3: In a write bit, `sda_o` takes the value of `cmd_wbit` at index l·s and holds it through the whole high phase. This includes s=8, where the change coincides with the SCL rise.
- R4: A start accepted from the idle bus keeps `scl_o` high and drops `sda_o` at index 8·h·u. It then drops `scl_o` at index 8·h·u + 8·h·(u+1), with `done` pulsing in that cycle. Both lines stay low afterwards.
- R5: A start accepted while the bus is held (after any bit) is a repeated start. `sda_o` rises at index l·s and `scl_o` rises at 8l. `sda_o` falls at 8l+8·h·u and `scl_o` falls at 8l+8·h·u+8·h·(u+1), with `done` pulsing in that cycle.
- R6: A read bit releases `sda_o` (value 1) at index l·s. It captures `sda_i` on the rising edge that ends index 8l+4h-1, which is the middle of the SCL high phase. It holds that value on `rd_bit` after `done`.
- R7: A stop drives `sda_o` low at index l·s and `scl_o` high at index 8l. It raises `sda_o` at index 8l+8·h·p, with `done` pulsing in that cycle, and leaves the bus idle.
- R8: `cmd_ready` is 0 while a command is in progress. A `cmd_valid` pulse during that time is ignored: it changes neither waveform, nor adds a `done` pulse, nor starts a command later.
- R9: Changes to `cfg_div`, `cfg_sda_upd`, `cfg_start_su` or `cfg_stop_su` after a command is accepted do not alter that command's waveform.
- R10: `version_o` reads 1, identifying the programmable-timing variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; all timing is counted in its cycles |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_div | input | 32 | Divider word: high divider in bits 31:16, low divider in bits 15:0, each stored minus one |
| cfg_sda_upd | input | 3 | SDA change point within the low phase, stored minus one |
| cfg_start_su | input | 2 | Start setup multiple of the high phase, stored minus one |
| cfg_stop_su | input | 2 | Stop setup multiple of the high phase, stored minus one |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command code: 0 start, 1 write, 2 read, 3 stop |
| cmd_wbit | input | 1 | Bit to send for a write command |
| cmd_ready | output | 1 | 1 when a new command can be accepted |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_o | output | 1 | SCL level, 1 = released |
| sda_o | output | 1 | SDA level, 1 = released |
| done | output | 1 | One-cycle pulse when the command's bus phase ends |
| rd_bit | output | 1 | SDA value captured by the last read bit |
| version_o | output | 16 | Variant identifier, constant 1 |

## Verification
Each result is due at a known index counted from the accepting edge. The low-phase SDA change lands at l·s and the SCL rise at 8l. The SCL fall of a bit and its `done` land at 8l+8h. Start and stop edges land at the multiples of 8h given above. All of these come from registered outputs with no extra pipeline stage.

The bench samples every output at the falling clock edge of each indexed cycle. It records the first index at which each line rises or falls and at which `done` appears, then compares those indices with the formulas. For reads, `sda_i` carries the expected value only during index 8l+4h-1 and the opposite value elsewhere, so a capture one cycle early or late shows up.

// File: rtl/i2c_bt_pkg.sv
// Package: shared widths, command and phase encodings, and the bundle of
// phase limits used by the bit timing generator.
// Assumes dividers are stored minus one and all limits are "last index".
package i2c_bt_pkg;

    localparam int BT_DIV_W = 16;   // width of each divider field
    localparam int BT_UPD_W = 3;    // width of the SDA update field
    localparam int BT_SU_W  = 2;    // width of each setup field
    // Longest phase is 8*h*(u+1) with h <= 2^DIV_W and u+1 <= 2^(SU_W+1).
    localparam int BT_CNT_W = BT_DIV_W + 3 + BT_SU_W + 1;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } bt_op_e;

    typedef enum logic [2:0] {
        P_IDLE = 3'd0,   // bus free, both lines released
        P_HELD = 3'd1,   // bus owned, SCL held low between commands
        P_LOW  = 3'd2,   // SCL low phase of a bit, restart or stop
        P_HIGH = 3'd3,   // SCL high phase of a data bit
        P_SSU  = 3'd4,   // start setup: SCL high, SDA high
        P_SHD  = 3'd5,   // start hold: SCL high, SDA low
        P_PSU  = 3'd6    // stop setup: SCL high, SDA low
    } bt_phase_e;

    typedef struct packed {
        logic [BT_CNT_W-1:0] low_last;
        logic [BT_CNT_W-1:0] upd_last;
        logic [BT_CNT_W-1:0] high_last;
        logic [BT_CNT_W-1:0] mid_last;
        logic [BT_CNT_W-1:0] ssu_last;
        logic [BT_CNT_W-1:0] shd_last;
        logic [BT_CNT_W-1:0] psu_last;
    } bt_lim_t;

endpackage

// File: rtl/i2c_bt_limits.sv
// Limits: converts the raw divider and tuning fields into the last counter
// index of every phase. Purely combinational; the caller registers the
// result when a command is accepted. Assumes the stored-minus-one encoding.
module i2c_bt_limits
    import i2c_bt_pkg::*;
(
    input  logic [2*BT_DIV_W-1:0] cfg_div,
    input  logic [BT_UPD_W-1:0]   cfg_sda_upd,
    input  logic [BT_SU_W-1:0]    cfg_start_su,
    input  logic [BT_SU_W-1:0]    cfg_stop_su,
    output bt_lim_t               lim
);

    localparam logic [BT_CNT_W-1:0] ONE = BT_CNT_W'(1);

    logic [BT_CNT_W-1:0] l_units;
    logic [BT_CNT_W-1:0] h_units;
    logic [BT_CNT_W-1:0] s_val;
    logic [BT_CNT_W-1:0] u_val;
    logic [BT_CNT_W-1:0] p_val;
    logic [BT_CNT_W-1:0] h_x_u;
    logic [BT_CNT_W-1:0] h_x_u1;
    logic [BT_CNT_W-1:0] h_x_p;

    // Decode the minus-one fields into unit counts.
    always_comb begin
        l_units = BT_CNT_W'(cfg_div[BT_DIV_W-1:0]) + ONE;
        h_units = BT_CNT_W'(cfg_div[2*BT_DIV_W-1:BT_DIV_W]) + ONE;
        s_val   = BT_CNT_W'(cfg_sda_upd) + ONE;
        u_val   = BT_CNT_W'(cfg_start_su) + ONE;
        p_val   = BT_CNT_W'(cfg_stop_su) + ONE;
    end

    // Products of the high unit count with the setup multiples.
    always_comb begin
        h_x_u  = h_units * u_val;
        h_x_u1 = h_units * (u_val + ONE);
        h_x_p  = h_units * p_val;
    end

    // Phase lengths expressed as the last index of an up counter.
    always_comb begin
        lim.low_last  = (l_units << 3) - ONE;
        lim.upd_last  = (l_units * s_val) - ONE;
        lim.high_last = (h_units << 3) - ONE;
        lim.mid_last  = (h_units << 2) - ONE;
        lim.ssu_last  = (h_x_u << 3) - ONE;
        lim.shd_last  = (h_x_u1 << 3) - ONE;
        lim.psu_last  = (h_x_p << 3) - ONE;
    end

endmodule

// File: rtl/i2c_bt_counter.sv
// Counter: phase cycle counter. Clears to zero on clr, otherwise counts up
// while en is high. Assumes the caller clears it at every phase boundary.
module i2c_bt_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    // Count cycles spent in the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/i2c_bt_match.sv
// Match: compares the phase counter with the captured limits and flags the
// last cycle of the current phase, the SDA update point in the low phase
// and the sampling point in the high phase. Purely combinational.
module i2c_bt_match
    import i2c_bt_pkg::*;
(
    input  bt_phase_e           phase,
    input  logic [BT_CNT_W-1:0] cnt,
    input  bt_lim_t             lim,
    output logic                ph_end,
    output logic                at_upd,
    output logic                at_mid
);

    // Select the end-of-phase comparison for the active phase.
    always_comb begin
        unique case (phase)
            P_LOW:   ph_end = (cnt == lim.low_last);
            P_HIGH:  ph_end = (cnt == lim.high_last);
            P_SSU:   ph_end = (cnt == lim.ssu_last);
            P_SHD:   ph_end = (cnt == lim.shd_last);
            P_PSU:   ph_end = (cnt == lim.psu_last);
            default: ph_end = 1'b0;
        endcase
    end

    // Mid-phase event points.
    always_comb begin
        at_upd = (phase == P_LOW)  && (cnt == lim.upd_last);
        at_mid = (phase == P_HIGH) && (cnt == lim.mid_last);
    end

endmodule

// File: rtl/i2c_bit_timer.sv
// Top: I2C master bit timing generator. Accepts one command at a time
// (start, write bit, read bit, stop) while the bus is idle or held, captures
// the timing configuration at acceptance, and sequences SCL/SDA through
// low, high and setup/hold phases counted in input clock cycles.
// Assumes outputs feed open-drain pads (1 = released) and that the byte
// engine above issues a start before any bit.
module i2c_bit_timer
    import i2c_bt_pkg::*;
#(
    parameter logic [15:0] VERSION = 16'd1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*BT_DIV_W-1:0] cfg_div,
    input  logic [BT_UPD_W-1:0]   cfg_sda_upd,
    input  logic [BT_SU_W-1:0]    cfg_start_su,
    input  logic [BT_SU_W-1:0]    cfg_stop_su,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic                  cmd_wbit,
    output logic                  cmd_ready,
    input  logic                  sda_i,
    output logic                  scl_o,
    output logic                  sda_o,
    output logic                  done,
    output logic                  rd_bit,
    output logic [15:0]           version_o
);

    bt_phase_e           phase_q;
    bt_op_e              op_q;
    logic                wbit_q;
    bt_lim_t             lim_d;
    bt_lim_t             lim_q;
    logic                scl_q;
    logic                sda_q;
    logic                done_q;
    logic                rd_q;
    logic [BT_CNT_W-1:0] cnt;
    logic                ph_end;
    logic                at_upd;
    logic                at_mid;
    logic                quiet;
    logic                accept;
    logic                busy;
    logic                low_target;
    bt_phase_e           after_low;

    i2c_bt_limits u_limits (
        .cfg_div      (cfg_div),
        .cfg_sda_upd  (cfg_sda_upd),
        .cfg_start_su (cfg_start_su),
        .cfg_stop_su  (cfg_stop_su),
        .lim          (lim_d)
    );

    i2c_bt_counter #(.W(BT_CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (busy),
        .clr   (accept | ph_end),
        .cnt   (cnt)
    );

    i2c_bt_match u_match (
        .phase  (phase_q),
        .cnt    (cnt),
        .lim    (lim_q),
        .ph_end (ph_end),
        .at_upd (at_upd),
        .at_mid (at_mid)
    );

    // Handshake: commands are taken only between bus phases.
    always_comb begin
        quiet  = (phase_q == P_IDLE) || (phase_q == P_HELD);
        busy   = !quiet;
        accept = cmd_valid && quiet;
    end

    // SDA value for the low phase and the phase that follows it.
    always_comb begin
        unique case (op_q)
            OP_WRITE: begin low_target = wbit_q; after_low = P_HIGH; end
            OP_READ:  begin low_target = 1'b1;   after_low = P_HIGH; end
            OP_STOP:  begin low_target = 1'b0;   after_low = P_PSU;  end
            default:  begin low_target = 1'b1;   after_low = P_SSU;  end
        endcase
    end

    // Phase sequencer driving the registered bus lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= P_IDLE;
            op_q    <= OP_START;
            wbit_q  <= 1'b0;
            lim_q   <= '0;
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            done_q  <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                P_IDLE, P_HELD: begin
                    if (accept) begin
                        lim_q  <= lim_d;
                        op_q   <= bt_op_e'(cmd_op);
                        wbit_q <= cmd_wbit;
                        if ((bt_op_e'(cmd_op) == OP_START) && (phase_q == P_IDLE)) begin
                            phase_q <= P_SSU;
                        end else begin
                            phase_q <= P_LOW;
                            scl_q   <= 1'b0;
                        end
                    end
                end
                P_LOW: begin
                    if (at_upd) begin
                        sda_q <= low_target;
                    end
                    if (ph_end) begin
                        scl_q   <= 1'b1;
                        phase_q <= after_low;
                    end
                end
                P_HIGH: begin
                    if (at_mid && (op_q == OP_READ)) begin
                        rd_q <= sda_i;
                    end
                    if (ph_end) begin
                        scl_q   <= 1'b0;
                        done_q  <= 1'b1;
                        phase_q <= P_HELD;
                    end
                end
                P_SSU: begin
                    if (ph_end) begin
                        sda_q   <= 1'b0;
                        phase_q <= P_SHD;
                    end
                end
                P_SHD: begin
                    if (ph_end) begin
                        scl_q   <= 1'b0;
                        done_q  <= 1'b1;
                        phase_q <= P_HELD;
                    end
                end
                P_PSU: begin
                    if (ph_end) begin
                        sda_q   <= 1'b1;
                        done_q  <= 1'b1;
                        phase_q <= P_IDLE;
                    end
                end
                default: phase_q <= P_IDLE;
            endcase
        end
    end

    // Output wiring.
    always_comb begin
        cmd_ready = quiet;
        scl_o     = scl_q;
        sda_o     = sda_q;
        done      = done_q;
        rd_bit    = rd_q;
        version_o = VERSION;
    end

endmodule

// File: rtl/i2c_bit_timer_chk.sv
// Checker: temporal properties of the bit timing generator, bound to the
// top module. Observes the bus lines, done, and the captured command/phase.
module i2c_bit_timer_chk
    import i2c_bt_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_o,
    input logic      sda_o,
    input logic      done,
    input bt_op_e    op_q,
    input bt_phase_e phase_q
);

    // R1: the idle bus has both lines released.
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == P_IDLE) |-> (scl_o && sda_o));

    // R2: a data bit ends with SCL falling in the done cycle.
    a_r2_bit_end_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ((op_q == OP_WRITE) || (op_q == OP_READ))) |-> (!scl_o && $past(scl_o)));

    // R3: SDA and SCL stay put once the high phase of a bit is under way.
    a_r3_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == P_HIGH) && ($past(phase_q) == P_HIGH)) |-> ($stable(sda_o) && $stable(scl_o)));

    // R4: a start ends with both lines low and SCL just fallen.
    a_r4_start_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_START)) |-> (!scl_o && !sda_o && $past(scl_o)));

    // R7: a stop ends with SDA just risen while SCL is high.
    a_r7_stop_end_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (op_q == OP_STOP)) |-> (scl_o && sda_o && !$past(sda_o)));

    // R8: done is a single-cycle pulse.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind i2c_bit_timer i2c_bit_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .done    (done),
    .op_q    (op_q),
    .phase_q (phase_q)
);

// File: tb/i2c_bit_timer_tb.sv
// Directed bench: one task per scenario; each records the first index of
// every line edge after the accepting clock edge and compares with the
// timing formulas of the requirements.
module i2c_bit_timer_tb;

    localparam logic [1:0] C_START = 2'd0;
    localparam logic [1:0] C_WRITE = 2'd1;
    localparam logic [1:0] C_READ  = 2'd2;
    localparam logic [1:0] C_STOP  = 2'd3;
    localparam int         MAXW    = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_div = '0;
    logic [2:0]  cfg_sda_upd = '0;
    logic [1:0]  cfg_start_su = '0;
    logic [1:0]  cfg_stop_su = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic        cmd_wbit = 1'b0;
    logic        cmd_ready;
    logic        sda_i = 1'b1;
    logic        scl_o;
    logic        sda_o;
    logic        done;
    logic        rd_bit;
    logic [15:0] version_o;

    int n_run = 0;
    int n_bad = 0;
    int t_sr, t_sf, t_cr, t_cf, t_dn, n_dn;
    logic poke_ready;

    always #4 clk = ~clk;   // 125 MHz

    i2c_bit_timer u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_div      (cfg_div),
        .cfg_sda_upd  (cfg_sda_upd),
        .cfg_start_su (cfg_start_su),
        .cfg_stop_su  (cfg_stop_su),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_wbit     (cmd_wbit),
        .cmd_ready    (cmd_ready),
        .sda_i        (sda_i),
        .scl_o        (scl_o),
        .sda_o        (sda_o),
        .done         (done),
        .rd_bit       (rd_bit),
        .version_o    (version_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [15:0] dh, input logic [15:0] dl,
                           input logic [2:0] su, input logic [1:0] st, input logic [1:0] sp);
        cfg_div      = {dh, dl};
        cfg_sda_upd  = su;
        cfg_start_su = st;
        cfg_stop_su  = sp;
    endtask

    // Issue one command and record the first index of every edge and of done.
    task automatic run_cmd(input logic [1:0] op, input logic wb, input int rd_at,
                           input logic rd_v, input int poke_at, input int cfg_at);
        logic ps, pd;
        t_sr = -1; t_sf = -1; t_cr = -1; t_cf = -1; t_dn = -1; n_dn = 0;
        poke_ready = 1'b1;
        @(negedge clk);
        ps = scl_o; pd = sda_o;
        cmd_op = op; cmd_wbit = wb; cmd_valid = 1'b1;
        @(posedge clk);
        for (int i = 0; i < MAXW; i++) begin
            @(negedge clk);
            if (i == 0) cmd_valid = 1'b0;
            if (scl_o && !ps && t_cr < 0) t_cr = i;
            if (!scl_o && ps && t_cf < 0) t_cf = i;
            if (sda_o && !pd && t_sr < 0) t_sr = i;
            if (!sda_o && pd && t_sf < 0) t_sf = i;
            ps = scl_o; pd = sda_o;
            if (done) begin
                n_dn++;
                if (t_dn < 0) t_dn = i;
            end
            if (rd_at >= 0) sda_i = (i == rd_at) ? rd_v : ~rd_v;
            else sda_i = 1'b1;
            if (i == poke_at) begin
                poke_ready = cmd_ready;
                cmd_op = C_STOP; cmd_valid = 1'b1;
            end
            if (poke_at >= 0 && i == poke_at + 5) cmd_valid = 1'b0;
            if (i == cfg_at) set_cfg(16'd0, 16'd0, 3'd0, 2'd0, 2'd0);
            if (t_dn >= 0 && i >= t_dn + 2) break;
        end
        sda_i = 1'b1;
        if (t_dn < 0) check("R2", "command never finished", 0, 1);
    endtask

    // Configuration A: l=3 h=2 s=3 u=2 p=4.
    task automatic cfg_a();
        set_cfg(16'd1, 16'd2, 3'd2, 2'd1, 2'd3);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "scl after reset", int'(scl_o), 1);
        check("R1", "sda after reset", int'(sda_o), 1);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "ready after reset", int'(cmd_ready), 1);
        check("R10", "version", int'(version_o), 1);
    endtask

    task automatic t_start_idle();
        cfg_a();
        run_cmd(C_START, 1'b0, -1, 1'b0, -1, -1);
        check("R4", "start sda fall", t_sf, 32);
        check("R4", "start scl fall", t_cf, 80);
        check("R4", "start done", t_dn, 80);
        check("R4", "start scl never rises", t_cr, -1);
        check("R8", "done pulses once", n_dn, 1);
    endtask

    task automatic t_write_bits();
        run_cmd(C_WRITE, 1'b1, -1, 1'b0, -1, -1);
        check("R3", "write1 sda rise", t_sr, 9);
        check("R2", "write1 scl rise", t_cr, 24);
        check("R2", "write1 scl fall", t_cf, 40);
        check("R2", "write1 done", t_dn, 40);
        run_cmd(C_WRITE, 1'b0, -1, 1'b0, -1, -1);
        check("R3", "write0 sda fall", t_sf, 9);
        check("R3", "write0 no sda rise", t_sr, -1);
        check("R2", "write0 scl fall", t_cf, 40);
    endtask

    task automatic t_read_bits();
        run_cmd(C_READ, 1'b0, 31, 1'b1, -1, -1);
        check("R6", "read releases sda", t_sr, 9);
        check("R6", "read captured 1", int'(rd_bit), 1);
        check("R2", "read done", t_dn, 40);
        run_cmd(C_READ, 1'b0, 31, 1'b0, -1, -1);
        check("R6", "read captured 0", int'(rd_bit), 0);
    endtask

    task automatic t_restart();
        run_cmd(C_WRITE, 1'b0, -1, 1'b0, -1, -1);
        run_cmd(C_START, 1'b0, -1, 1'b0, -1, -1);
        check("R5", "restart sda rise", t_sr, 9);
        check("R5", "restart scl rise", t_cr, 24);
        check("R5", "restart sda fall", t_sf, 56);
        check("R5", "restart scl fall", t_cf, 104);
        check("R5", "restart done", t_dn, 104);
    endtask

    task automatic t_busy_ignored();
        run_cmd(C_WRITE, 1'b1, -1, 1'b0, 3, -1);
        check("R8", "ready while busy", int'(poke_ready), 0);
        check("R8", "busy write sda rise", t_sr, 9);
        check("R8", "busy write scl fall", t_cf, 40);
        check("R8", "single done", n_dn, 1);
        check("R8", "no late stop scl", int'(scl_o), 0);
        check("R8", "ready after", int'(cmd_ready), 1);
    endtask

    task automatic t_stop();
        run_cmd(C_STOP, 1'b0, -1, 1'b0, -1, -1);
        check("R7", "stop sda fall", t_sf, 9);
        check("R7", "stop scl rise", t_cr, 24);
        check("R7", "stop sda rise", t_sr, 88);
        check("R7", "stop done", t_dn, 88);
        check("R1", "idle scl", int'(scl_o), 1);
        check("R1", "idle sda", int'(sda_o), 1);
        check("R1", "idle ready", int'(cmd_ready), 1);
    endtask

    task automatic t_cfg_capture();
        cfg_a();
        run_cmd(C_START, 1'b0, -1, 1'b0, -1, 5);
        check("R9", "start sda fall kept", t_sf, 32);
        check("R9", "start scl fall kept", t_cf, 80);
        cfg_a();
        run_cmd(C_STOP, 1'b0, -1, 1'b0, -1, -1);
        check("R7", "stop scl rise", t_cr, 24);
        check("R7", "stop sda rise", t_sr, 88);
    endtask

    task automatic t_minimum();
        set_cfg(16'd0, 16'd0, 3'd0, 2'd0, 2'd0);
        run_cmd(C_START, 1'b0, -1, 1'b0, -1, -1);
        check("R4", "min start sda fall", t_sf, 8);
        check("R4", "min start scl fall", t_cf, 24);
        run_cmd(C_WRITE, 1'b1, -1, 1'b0, -1, -1);
        check("R3", "min write sda rise", t_sr, 1);
        check("R2", "min write scl rise", t_cr, 8);
        check("R2", "min write scl fall", t_cf, 16);
        run_cmd(C_STOP, 1'b0, -1, 1'b0, -1, -1);
        check("R7", "min stop sda fall", t_sf, 1);
        check("R7", "min stop scl rise", t_cr, 8);
        check("R7", "min stop sda rise", t_sr, 16);
    endtask

    task automatic t_late_update();
        set_cfg(16'd0, 16'd1, 3'd7, 2'd0, 2'd0);
        run_cmd(C_START, 1'b0, -1, 1'b0, -1, -1);
        check("R4", "late start sda fall", t_sf, 8);
        check("R4", "late start scl fall", t_cf, 24);
        run_cmd(C_WRITE, 1'b1, -1, 1'b0, -1, -1);
        check("R3", "s=8 sda rise", t_sr, 16);
        check("R3", "s=8 scl rise", t_cr, 16);
        check("R2", "s=8 scl fall", t_cf, 24);
        run_cmd(C_STOP, 1'b0, -1, 1'b0, -1, -1);
        check("R7", "s=8 stop sda fall", t_sf, 16);
        check("R7", "s=8 stop sda rise", t_sr, 24);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_start_idle();
        t_write_bits();
        t_read_bits();
        t_restart();
        t_busy_ignored();
        t_stop();
        t_cfg_capture();
        t_minimum();
        t_late_update();
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

endmodule